// File: doc/BRIEF.md
# Masked Vector Gather/Scatter Sequencer

This block moves sixteen 32-bit elements between a vector and memory. Each element has its own address: a common base plus the lane's offset, with the offset multiplied by 1, 2, 4 or 8. A lane mask chooses which lanes take part. In gather mode the block reads memory into the enabled lanes of a destination vector. In scatter mode it writes the enabled lanes of a source vector to memory.

The memory side is a single port that works on whole 64-byte lines. On each access the sequencer picks the line of the lowest-numbered lane that is still pending. Every pending lane in that line is served by that one access, so a gather whose lanes all fall in one line needs one access. As lanes complete, their mask bits clear. When the mask reaches zero the block pulses `done`.

A caller loads the destination vector's old contents through `vec_in`, so lanes that are masked off keep their old value. The caller pulses `start` and waits for `done`.

Top module: `gs_engine`

## Requirements
- R1: Lane i's byte address is `base + (offset_i << scale_sel)`, with scale_sel 0/1/2/3 meaning ×1/×2/×4/×8, computed modulo 2^32. The two low address bits are ignored (word access). Address bits [5:2] select the 32-bit word in the line, and the line address is the lane address with bits [5:0] cleared.
- R2: A lane whose mask bit is 0 at start causes no memory access, and its element of `vec_out` keeps the value loaded from `vec_in`.
- R3: `mask_out` holds the start mask and only ever loses bits. A gather lane's bit clears on the clock edge that writes its data. A scatter lane's bit clears on the edge where its write is accepted.
- R4: Each access uses the line of the lowest-numbered pending lane. All pending lanes in that line retire on that access, so the number of accesses equals the number of distinct lines among the enabled lanes.
- R5: Enabled lanes that share an address each receive the same memory word.
- R6: `mem_rdata` carries the requested line in the cycle after the request (byte b of the line in bits [8b+7:8b], little-endian words). A gather touching L lines raises `done` L+1 cycles after the first request cycle, and `done` is high for one cycle.
- R7: In scatter mode `mem_we` is high with each request, and `mem_be` marks the four bytes of every lane that retires on that access. When several lanes hit one address, the highest-numbered lane's value is the one written. A scatter touching L lines raises `done` L cycles after the first request cycle.
- R8: A start with an all-zero mask makes no memory request and raises `done` in the cycle after the start edge.
- R9: `busy` is high from the start edge until the operation finishes. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| scatter | input | 1 | 1 = scatter (write), 0 = gather (read) |
| base | input | 32 | Common byte base address |
| offsets | input | 512 | Sixteen 32-bit lane offsets, lane i in bits [32i+31:32i] |
| scale_sel | input | 2 | Offset multiplier select: ×1, ×2, ×4, ×8 |
| mask_in | input | 16 | Lane enables |
| vec_in | input | 512 | Gather: initial destination contents; scatter: source data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | 16 | Lanes not yet completed |
| vec_out | output | 512 | Destination vector |
| mem_req | output | 1 | Memory line access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 512 | Write line data |
| mem_be | output | 64 | Byte enables of the write |
| mem_rdata | input | 512 | Read line, valid the cycle after a request |

## Verification
The assertions check rules that hold on every cycle:
- a request only retires lanes that are pending, and it retires at least one;
- the mask never regains a bit while an operation runs;
- a masked-off lane's element never changes;
- writes happen only in scatter mode;
- the latched operands stay stable while busy;
- `done` only appears once the mask is empty.

Other behaviour needs the bench's scenarios, because it depends on values computed from memory contents:
- the exact line chosen on each access;
- the total number of accesses and the cycle on which the operation finishes;
- the gathered words and the duplicate-address results;
- the winning lane of a scatter collision.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gs_state_e;
endpackage

// File: rtl/gs_lane_addr.sv
module gs_lane_addr #(
    parameter int AW  = 32,
    parameter int OFW = 32,
    parameter int SCW = 2
) (
    input  logic [AW-1:0]  base,
    input  logic [OFW-1:0] offset,
    input  logic [SCW-1:0] scale_sel,
    output logic [AW-1:0]  addr
);
    // Element address: base plus offset shifted by the scale selector.
    always_comb begin
        addr = base + (AW'(offset) << scale_sel);
    end
endmodule

// File: rtl/gs_line_pick.sv
module gs_line_pick #(
    parameter int LANES = 16,
    parameter int AW    = 32,
    parameter int LSB   = 6
) (
    input  logic [LANES-1:0][AW-1:0] lane_addr,
    input  logic [LANES-1:0]         pend,
    output logic [LANES-1:0]         hit,
    output logic [AW-1:0]            line_addr
);
    logic              found;
    logic [AW-LSB-1:0] tag;

    // The lowest pending lane chooses the line.
    always_comb begin
        found = 1'b0;
        tag   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && !found) begin
                found = 1'b1;
                tag   = lane_addr[i][AW-1:LSB];
            end
        end
        line_addr = {tag, {LSB{1'b0}}};
    end

    // Every pending lane in that line retires on this access.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_hit
            assign hit[g] = pend[g] && (lane_addr[g][AW-1:LSB] == tag);
        end
    endgenerate
endmodule

// File: rtl/gs_scatter_pack.sv
module gs_scatter_pack #(
    parameter int LANES      = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [LANES-1:0][AW-1:0] lane_addr,
    input  logic [LANES-1:0]         hit,
    input  logic [LANES-1:0][DW-1:0] vec,
    output logic [LINE_BYTES*8-1:0]  wdata,
    output logic [LINE_BYTES-1:0]    wbe
);
    localparam int LSB  = $clog2(LINE_BYTES);
    localparam int WB   = DW / 8;
    localparam int WSH  = $clog2(WB);
    localparam int WIDX = LSB - WSH;

    // Ascending lane order: a later (higher) lane overwrites an earlier one.
    always_comb begin
        wdata = '0;
        wbe   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i]) begin
                wdata[int'(lane_addr[i][LSB-1:WSH])*DW +: DW] = vec[i];
                wbe[int'(lane_addr[i][LSB-1:WSH])*WB +: WB]   = {WB{1'b1}};
            end
        end
    end

    logic [WIDX-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/gs_engine.sv
module gs_engine
    import gs_pkg::*;
#(
    parameter int LANES      = 16,
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int SCW        = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    scatter,
    input  logic [AW-1:0]           base,
    input  logic [LANES*DW-1:0]     offsets,
    input  logic [SCW-1:0]          scale_sel,
    input  logic [LANES-1:0]        mask_in,
    input  logic [LANES*DW-1:0]     vec_in,
    output logic                    busy,
    output logic                    done,
    output logic [LANES-1:0]        mask_out,
    output logic [LANES*DW-1:0]     vec_out,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_be,
    input  logic [LINE_BYTES*8-1:0] mem_rdata
);
    localparam int LSB = $clog2(LINE_BYTES);
    localparam int WSH = $clog2(DW / 8);

    typedef struct packed {
        gs_state_e               st;
        logic                    scat;
        logic [AW-1:0]           base;
        logic [SCW-1:0]          scl;
        logic [LANES-1:0][DW-1:0] offs;
        logic [LANES-1:0][DW-1:0] data;
        logic [LANES-1:0]        mask;
        logic [LANES-1:0]        pend;
        logic [LANES-1:0]        cap;
        logic                    done;
    } gs_regs_t;

    gs_regs_t r_q, r_d;

    logic [LANES-1:0][AW-1:0] lane_addr;
    logic [LANES-1:0]         hit;
    logic [AW-1:0]            line_addr;
    logic [LINE_BYTES*8-1:0]  pk_wdata;
    logic [LINE_BYTES-1:0]    pk_be;
    logic                     issue;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_addr
            gs_lane_addr #(.AW(AW), .OFW(DW), .SCW(SCW)) u_addr (
                .base      (r_q.base),
                .offset    (r_q.offs[g]),
                .scale_sel (r_q.scl),
                .addr      (lane_addr[g])
            );
        end
    endgenerate

    gs_line_pick #(.LANES(LANES), .AW(AW), .LSB(LSB)) u_pick (
        .lane_addr (lane_addr),
        .pend      (r_q.pend),
        .hit       (hit),
        .line_addr (line_addr)
    );

    gs_scatter_pack #(.LANES(LANES), .AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) u_pack (
        .lane_addr (lane_addr),
        .hit       (hit),
        .vec       (r_q.data),
        .wdata     (pk_wdata),
        .wbe       (pk_be)
    );

    assign issue = (r_q.st == ST_RUN) && (|r_q.pend);

    always_comb begin
        logic [LANES-1:0] iss;
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cap  = '0;
        iss      = issue ? hit : '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.scat = scatter;
                    r_d.base = base;
                    r_d.scl  = scale_sel;
                    r_d.offs = offsets;
                    r_d.data = vec_in;
                    r_d.mask = mask_in;
                    r_d.pend = mask_in;
                    if (mask_in == '0) r_d.done = 1'b1;
                    else               r_d.st   = ST_RUN;
                end
            end
            default: begin
                r_d.pend = r_q.pend & ~iss;
                if (r_q.scat) begin
                    r_d.mask = r_q.mask & ~iss;
                end else begin
                    r_d.cap  = iss;
                    r_d.mask = r_q.mask & ~r_q.cap;
                    for (int i = 0; i < LANES; i++) begin
                        if (r_q.cap[i])
                            r_d.data[i] = mem_rdata[int'(lane_addr[i][LSB-1:WSH])*DW +: DW];
                    end
                end
                if (r_d.mask == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_RUN);
    assign done      = r_q.done;
    assign mask_out  = r_q.mask;
    assign vec_out   = r_q.data;
    assign mem_req   = issue;
    assign mem_we    = issue && r_q.scat;
    assign mem_addr  = line_addr;
    assign mem_wdata = pk_wdata;
    assign mem_be    = mem_we ? pk_be : '0;

    // R4: an access retires only pending lanes, and at least one of them
    a_r4_hit_in_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((hit & ~r_q.pend) == '0) && (hit != '0));

    // R3: while running the mask never gains a bit
    a_r3_mask_only_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> ((mask_out & ~$past(mask_out)) == '0));

    // R7: writes only in scatter mode
    a_r7_write_only_scatter: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && r_q.scat));

    // R8: completion only once every lane has retired
    a_r8_done_mask_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mask_out == '0 && !busy));

    // R9: latched operands stay fixed while busy
    a_r9_operands_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> ($stable(r_q.base) && $stable(r_q.offs) && $stable(r_q.scl)));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_chk
            // R2: a lane out of the mask keeps its element
            a_r2_idle_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (busy && !mask_out[g]) |=> $stable(vec_out[g*DW +: DW]));
        end
    endgenerate
endmodule

// File: tb/tb_gs_engine.sv
module tb_gs_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         scatter = 1'b0;
    logic [31:0]  base = '0;
    logic [511:0] offsets = '0;
    logic [1:0]   scale_sel = '0;
    logic [15:0]  mask_in = '0;
    logic [511:0] vec_in = '0;
    logic         busy, done;
    logic [15:0]  mask_out;
    logic [511:0] vec_out;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic [63:0]  mem_be;
    logic [511:0] mem_rdata = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0]  mem     [4096];
    logic [7:0]  exp_mem [4096];
    logic [31:0] offs_t  [16];
    logic [31:0] vec_t   [16];

    always #5 clk = ~clk;

    gs_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .scatter(scatter), .base(base),
        .offsets(offsets), .scale_sel(scale_sel), .mask_in(mask_in), .vec_in(vec_in),
        .busy(busy), .done(done), .mask_out(mask_out), .vec_out(vec_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    // Line memory: write on request edge, read data valid the following cycle.
    always @(posedge clk) begin
        if (mem_req) begin
            for (int b = 0; b < 64; b++) begin
                if (mem_we) begin
                    if (mem_be[b]) mem[int'(mem_addr[11:6]) * 64 + b] <= mem_wdata[b*8 +: 8];
                end else begin
                    mem_rdata[b*8 +: 8] <= mem[int'(mem_addr[11:6]) * 64 + b];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_a(input logic [31:0] b, input logic [31:0] o, input logic [1:0] s);
        return b + (o << s);
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        int p;
        p = int'(a[11:2]) * 4;
        return {exp_mem[p+3], exp_mem[p+2], exp_mem[p+1], exp_mem[p]};
    endfunction

    task automatic run_op(input bit sc, input logic [31:0] b, input logic [1:0] s,
                          input logic [15:0] m, input bit poke, input string tag);
        logic [31:0]  la [16];
        logic [31:0]  ln [16];
        logic [511:0] exp_vec;
        logic [15:0]  pend, mexp, capp, hitb, seen;
        int lines, reqs, k, expk;
        bit mem_ok;
        lines = 0;
        seen  = '0;
        for (int i = 0; i < 16; i++) begin
            la[i] = lane_a(b, offs_t[i], s);
            ln[i] = la[i] & 32'hFFFF_FFC0;
        end
        for (int i = 0; i < 16; i++) begin
            if (m[i] && !seen[i]) begin
                lines++;
                for (int j = i; j < 16; j++) if (m[j] && ln[j] == ln[i]) seen[j] = 1'b1;
            end
        end
        for (int a = 0; a < 4096; a++) exp_mem[a] = mem[a];
        for (int i = 0; i < 16; i++) exp_vec[i*32 +: 32] = (!sc && m[i]) ? rd_word(la[i]) : vec_t[i];
        if (sc) begin
            for (int i = 0; i < 16; i++) begin
                if (m[i]) begin
                    int p;
                    p = int'(la[i][11:2]) * 4;
                    {exp_mem[p+3], exp_mem[p+2], exp_mem[p+1], exp_mem[p]} = vec_t[i];
                end
            end
        end
        @(negedge clk);
        scatter = sc; base = b; scale_sel = s; mask_in = m;
        for (int i = 0; i < 16; i++) begin
            offsets[i*32 +: 32] = offs_t[i];
            vec_in[i*32 +: 32]  = vec_t[i];
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1; reqs = 0; pend = m; mexp = m; capp = '0;
        while (!done && k < 80) begin
            chk(mask_out == mexp, {tag, " R3 mask progress"}, 512'(mask_out), 512'(mexp));
            if (k == 1) chk(busy == (m != 0), {tag, " R9 busy"}, 512'(busy), 512'(m != 0));
            hitb = '0;
            if (mem_req) begin
                int j;
                j = 0;
                for (int i = 15; i >= 0; i--) if (pend[i]) j = i;
                chk(mem_addr == ln[j], {tag, " R4 line order"}, 512'(mem_addr), 512'(ln[j]));
                chk(mem_we == sc, {tag, " R7 write flag"}, 512'(mem_we), 512'(sc));
                for (int i = 0; i < 16; i++) if (pend[i] && ln[i] == ln[j]) hitb[i] = 1'b1;
                pend = pend & ~hitb;
                reqs++;
            end
            if (sc) mexp = mexp & ~hitb;
            else begin
                mexp = mexp & ~capp;
                capp = hitb;
            end
            if (poke && k == 1) begin
                start = 1'b1; base = 32'h0000_0100; mask_in = 16'hFFFF; scatter = ~sc;
            end
            if (poke && k == 2) start = 1'b0;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        expk = (m == 0) ? 1 : (sc ? lines + 1 : lines + 2);
        chk(k == expk, {tag, (m == 0) ? " R8 latency" : (sc ? " R7 latency" : " R6 latency")},
            512'(k), 512'(expk));
        chk(reqs == lines, {tag, " R4 access count"}, 512'(reqs), 512'(lines));
        chk(mask_out == 16'h0, {tag, " R3 mask empty"}, 512'(mask_out), 512'(0));
        if (!sc) begin
            chk(vec_out == exp_vec, {tag, " R1/R2/R5 gather data"}, vec_out, exp_vec);
        end else begin
            mem_ok = 1'b1;
            for (int a = 0; a < 4096; a++) if (mem[a] !== exp_mem[a]) mem_ok = 1'b0;
            chk(mem_ok, {tag, " R7 scatter memory"}, 512'(mem_ok), 512'(1));
        end
        @(negedge clk);
        chk(!done, {tag, " R6 done one cycle"}, 512'(done), 512'(0));
    endtask

    initial begin
        void'($urandom(32'h5A17));
        for (int a = 0; a < 4096; a++) mem[a] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req && mask_out == 0, "R9 reset state",
            {busy, done, mem_req, mask_out}, 512'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R5: all lanes one address, one access
        for (int i = 0; i < 16; i++) begin offs_t[i] = 32'd12; vec_t[i] = 32'hDEAD_0000 + i; end
        run_op(1'b0, 32'h0000_0200, 2'd2, 16'hFFFF, 1'b0, "same-addr");
        // R1/R4: sixteen distinct lines, scale x8
        for (int i = 0; i < 16; i++) begin offs_t[i] = 32'(15 - i) * 8; vec_t[i] = 32'(i); end
        run_op(1'b0, 32'h0000_0044, 2'd3, 16'hFFFF, 1'b0, "spread-x8");
        // R2: sparse mask keeps old values
        for (int i = 0; i < 16; i++) begin offs_t[i] = 32'(i * 3); vec_t[i] = 32'hA5A5_0000 | i; end
        run_op(1'b0, 32'h0000_0301, 2'd0, 16'b1010_0000_0110_0011, 1'b0, "sparse");
        // R8: empty masks in both modes
        run_op(1'b0, 32'h0000_0000, 2'd1, 16'h0000, 1'b0, "empty-g");
        run_op(1'b1, 32'h0000_0000, 2'd1, 16'h0000, 1'b0, "empty-s");
        // R7: collision, lane 15 wins
        for (int i = 0; i < 16; i++) begin offs_t[i] = 32'd5; vec_t[i] = 32'h1111_1100 + i; end
        run_op(1'b1, 32'h0000_0400, 2'd2, 16'hFFFF, 1'b0, "collide");
        // R9: start while busy ignored
        for (int i = 0; i < 16; i++) begin offs_t[i] = 32'(i * 20); vec_t[i] = 32'(i); end
        run_op(1'b0, 32'h0000_0080, 2'd2, 16'hF0F3, 1'b1, "poke");

        for (int n = 0; n < 60; n++) begin
            bit sc;
            logic [15:0] m;
            int span;
            sc   = 1'($urandom);
            span = ($urandom % 2) ? 16 : 256;
            m    = 16'($urandom);
            for (int i = 0; i < 16; i++) begin
                offs_t[i] = $urandom % span;
                vec_t[i]  = $urandom;
            end
            run_op(sc, $urandom % 2048, 2'($urandom), m, 1'b0, "random");
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule